// File: doc/BRIEF.md
# Byte-Lane Steering Bus Interface

This block connects a 16-bit core data port to a 16-bit external memory bus that addresses individual bytes over a 20-bit byte address, so it can reach 1,048,576 locations. The core issues one read or write at a time, of either a byte or a 16-bit word, by pulsing a request. The block then drives one or two bus cycles and answers with a one-clock done pulse.

Each bus cycle carries two lane enables. The low lane (bits 7..0) is enabled while bus address bit 0 is low. The high lane (bits 15..8) is enabled while the active-low high-byte enable is low. A byte travels on the lane its address parity selects. A word at an even address uses both lanes in one cycle. A word at an odd address N is split into two back-to-back cycles: N on the high lane, then N+1 on the low lane. The bytes are stored little-endian, so the byte at the lower address is the low-order byte.

The external memory answers in the same cycle it is addressed. Read data is returned right-aligned and registered, and it is held until the next read completes.

Top module: `byte_lane_bif`

## Requirements
- R1: A byte access at an even address N makes one bus cycle with bus_addr = N and bus_bhe_n = 1, so only the low lane is enabled. On a write the byte req_wdata[7:0] appears on bus_wdata[7:0].
- R2: A byte access at an odd address N makes one bus cycle with bus_addr = N and bus_bhe_n = 0, so only the high lane is enabled. On a write the byte req_wdata[7:0] appears on bus_wdata[15:8].
- R3: A byte read returns the addressed byte in req_rdata[7:0], whichever lane it came from, with req_rdata[15:8] = 0.
- R4: A word access at an even address N makes a single bus cycle with bus_addr = N and bus_bhe_n = 0. A write drives req_wdata unchanged, and a read returns bus_rdata unchanged.
- R5: A word access at an odd address N makes two consecutive bus cycles. The first has bus_addr = N and bus_bhe_n = 0, with req_wdata[7:0] on bus_wdata[15:8]. The second has bus_addr = N+1 and bus_bhe_n = 1, with req_wdata[15:8] on bus_wdata[7:0].
- R6: A word read at an odd address N returns {byte(N+1), byte(N)}.
- R7: req_done is high for exactly one clock, in the cycle right after the final bus cycle of a request. bus_cyc is low in that cycle.
- R8: A request presented while an access is in progress is ignored and starts no bus cycle.
- R9: When no bus cycle is active, bus_cyc = 0, bus_we = 0, bus_bhe_n = 1, bus_addr = 0 and bus_wdata = 0. During a write, the bits of a disabled lane are driven to 0.
- R10: The second cycle of a split word at address 0xFFFFF uses address 0x00000.
- R11: During and directly after reset, req_done = 0, req_rdata = 0 and the bus is idle.
- R12: req_rdata is unchanged by write requests and keeps the value of the last completed read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request pulse, taken while no access is in progress |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_addr | input | 20 | Byte address |
| req_wdata | input | 16 | Write data; a byte uses bits 7..0 |
| req_done | output | 1 | One-clock completion pulse |
| req_rdata | output | 16 | Read result, right-aligned for bytes |
| bus_cyc | output | 1 | Bus cycle active |
| bus_we | output | 1 | Bus cycle is a write |
| bus_addr | output | 20 | Bus byte address; bit 0 low enables the low lane |
| bus_bhe_n | output | 1 | Active-low high-lane enable |
| bus_wdata | output | 16 | Bus write data |
| bus_rdata | input | 16 | Bus read data, valid in the addressed cycle |

## Verification
Request acceptance and split sequencing can fall in the same cycle. The bench holds req_valid high through both halves of an odd-address word and expects that no third bus cycle follows and that the done pulse appears only once. A second overlap is the done cycle and a fresh request. The bench drops the request before the done edge and checks that the bus stays idle afterwards. The expected data is compared against a byte-wide reference memory kept separately from the bus-side memory.

// File: rtl/byte_lane_pkg.sv
package byte_lane_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_SECOND = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    LN_LOW  = 2'd0,
    LN_HIGH = 2'd1,
    LN_BOTH = 2'd2
  } lane_e;
endpackage

// File: rtl/bl_addr_gen.sv
module bl_addr_gen
  import byte_lane_pkg::*;
#(
  parameter int AW = 20
) (
  input  phase_e          phase,
  input  logic            word,
  input  logic [AW-1:0]   addr,
  output logic            cyc,
  output logic [AW-1:0]   cyc_addr,
  output lane_e           lane
);
  localparam logic [AW-1:0] ONE = AW'(1);

  always_comb begin
    cyc      = 1'b0;
    cyc_addr = '0;
    lane     = LN_LOW;
    unique case (phase)
      PH_FIRST: begin
        cyc      = 1'b1;
        cyc_addr = addr;
        if (addr[0])   lane = LN_HIGH;
        else if (word) lane = LN_BOTH;
        else           lane = LN_LOW;
      end
      PH_SECOND: begin
        cyc      = 1'b1;
        cyc_addr = addr + ONE;
        lane     = LN_LOW;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bl_wr_steer.sv
module bl_wr_steer
  import byte_lane_pkg::*;
#(
  parameter int DW = 16
) (
  input  lane_e          lane,
  input  logic           second,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  lanes
);
  localparam int BW = DW / 2;

  always_comb begin
    lanes = '0;
    unique case (lane)
      LN_BOTH: lanes = wdata;
      LN_HIGH: lanes[DW-1:BW] = wdata[BW-1:0];
      default: lanes[BW-1:0]  = second ? wdata[DW-1:BW] : wdata[BW-1:0];
    endcase
  end
endmodule

// File: rtl/bl_rd_merge.sv
module bl_rd_merge
  import byte_lane_pkg::*;
#(
  parameter int DW = 16
) (
  input  lane_e              lane,
  input  logic               second,
  input  logic [DW/2-1:0]    held,
  input  logic [DW-1:0]      bus_rdata,
  output logic [DW-1:0]      merged
);
  localparam int BW = DW / 2;

  always_comb begin
    merged = '0;
    if (second) begin
      merged = {bus_rdata[BW-1:0], held};
    end else begin
      unique case (lane)
        LN_BOTH: merged = bus_rdata;
        LN_HIGH: merged[BW-1:0] = bus_rdata[DW-1:BW];
        default: merged[BW-1:0] = bus_rdata[BW-1:0];
      endcase
    end
  end
endmodule

// File: rtl/byte_lane_bif.sv
module byte_lane_bif
  import byte_lane_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic           req_write,
  input  logic           req_word,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_wdata,
  output logic           req_done,
  output logic [DW-1:0]  req_rdata,
  output logic           bus_cyc,
  output logic           bus_we,
  output logic [AW-1:0]  bus_addr,
  output logic           bus_bhe_n,
  output logic [DW-1:0]  bus_wdata,
  input  logic [DW-1:0]  bus_rdata
);
  localparam int BW = DW / 2;

  phase_e          phase_q, phase_d;
  logic            wr_q, word_q;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wdata_q;
  logic [BW-1:0]   held_q, held_d;
  logic [DW-1:0]   rdata_q, rdata_d;
  logic            done_q, done_d;

  logic            accept, split, last_cyc, cap_held, second;
  logic            cyc;
  logic [AW-1:0]   cyc_addr;
  lane_e           lane;
  logic [DW-1:0]   steer_data, merged;

  assign accept = (phase_q == PH_IDLE) && req_valid;
  assign split  = word_q && addr_q[0];
  assign second = (phase_q == PH_SECOND);

  bl_addr_gen #(.AW(AW)) u_addr (
    .phase    (phase_q),
    .word     (word_q),
    .addr     (addr_q),
    .cyc      (cyc),
    .cyc_addr (cyc_addr),
    .lane     (lane)
  );

  bl_wr_steer #(.DW(DW)) u_steer (
    .lane   (lane),
    .second (second),
    .wdata  (wdata_q),
    .lanes  (steer_data)
  );

  bl_rd_merge #(.DW(DW)) u_merge (
    .lane      (lane),
    .second    (second),
    .held      (held_q),
    .bus_rdata (bus_rdata),
    .merged    (merged)
  );

  // next-state logic
  always_comb begin
    phase_d  = phase_q;
    last_cyc = 1'b0;
    cap_held = 1'b0;
    unique case (phase_q)
      PH_IDLE:   if (accept) phase_d = PH_FIRST;
      PH_FIRST: begin
        if (split) begin
          phase_d  = PH_SECOND;
          cap_held = 1'b1;
        end else begin
          phase_d  = PH_IDLE;
          last_cyc = 1'b1;
        end
      end
      PH_SECOND: begin
        phase_d  = PH_IDLE;
        last_cyc = 1'b1;
      end
      default:   phase_d = PH_IDLE;
    endcase
    done_d  = last_cyc;
    held_d  = cap_held ? bus_rdata[DW-1:BW] : held_q;
    rdata_d = (last_cyc && !wr_q) ? merged : rdata_q;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      done_q  <= 1'b0;
      held_q  <= '0;
      rdata_q <= '0;
    end else begin
      phase_q <= phase_d;
      done_q  <= done_d;
      held_q  <= held_d;
      rdata_q <= rdata_d;
    end
  end

  // request capture with explicit enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      word_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      wr_q    <= req_write;
      word_q  <= req_word;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  assign req_done  = done_q;
  assign req_rdata = rdata_q;
  assign bus_cyc   = cyc;
  assign bus_we    = cyc && wr_q;
  assign bus_addr  = cyc ? cyc_addr : '0;
  assign bus_bhe_n = !(cyc && (lane == LN_HIGH || lane == LN_BOTH));
  assign bus_wdata = (cyc && wr_q) ? steer_data : '0;
endmodule

// File: rtl/byte_lane_bif_chk.sv
module byte_lane_bif_chk #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_done,
  input logic           bus_cyc,
  input logic           bus_we,
  input logic [AW-1:0]  bus_addr,
  input logic           bus_bhe_n,
  input logic [DW-1:0]  bus_wdata
);
  localparam int BW = DW / 2;
  localparam logic [AW-1:0] ONE = AW'(1);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |=> !req_done) else $error("done longer than one cycle"); // R7

  AST_DONE_AFTER_CYC: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |-> ($past(bus_cyc) && !bus_cyc)) else $error("done misplaced"); // R7

  AST_LANE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc |-> !(bus_addr[0] && bus_bhe_n)) else $error("no lane enabled"); // R1

  AST_SPLIT_NEXT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && $past(bus_cyc)) |-> (bus_addr == $past(bus_addr) + ONE && bus_bhe_n && !$past(bus_bhe_n)))
    else $error("split order broken"); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_cyc |-> (bus_bhe_n && !bus_we && bus_addr == '0 && bus_wdata == '0))
    else $error("idle bus not quiet"); // R9

  AST_HIGH_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && bus_we && bus_bhe_n) |-> bus_wdata[DW-1:BW] == '0)
    else $error("disabled high lane driven"); // R9

  AST_LOW_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && bus_we && bus_addr[0]) |-> bus_wdata[BW-1:0] == '0)
    else $error("disabled low lane driven"); // R9
endmodule

bind byte_lane_bif byte_lane_bif_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_done  (req_done),
  .bus_cyc   (bus_cyc),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_bhe_n (bus_bhe_n),
  .bus_wdata (bus_wdata)
);

// File: tb/byte_lane_bif_bench.sv
`timescale 1ns/1ps
module byte_lane_bif_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_word;
  logic [19:0] req_addr;
  logic [15:0] req_wdata;
  logic        req_done;
  logic [15:0] req_rdata;
  logic        bus_cyc, bus_we, bus_bhe_n;
  logic [19:0] bus_addr;
  logic [15:0] bus_wdata, bus_rdata;

  int checks = 0;
  int errors = 0;
  bit ended  = 0;
  int mem_ver = 0;

  logic [7:0] bus_mem [int];
  logic [7:0] ref_mem [int];
  logic [15:0] exp_rdata;

  always #2 clk = ~clk;

  byte_lane_bif u_byte_lane_bif (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_done(req_done), .req_rdata(req_rdata), .bus_cyc(bus_cyc),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_bhe_n(bus_bhe_n),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  function automatic logic [7:0] rd_byte(int k);
    if (bus_mem.exists(k)) return bus_mem[k];
    return 8'h00;
  endfunction

  function automatic logic [15:0] mem_word(logic [19:0] a, int ver);
    int e;
    e = int'(a) & 32'hFFFFE;
    return (ver >= 0) ? {rd_byte(e + 1), rd_byte(e)} : 16'h0;
  endfunction

  assign bus_rdata = mem_word(bus_addr, mem_ver);

  always @(posedge clk) begin
    if (bus_cyc && bus_we) begin
      if (!bus_addr[0]) bus_mem[int'(bus_addr)] = bus_wdata[7:0];
      if (!bus_bhe_n)   bus_mem[int'(bus_addr) | 1] = bus_wdata[15:8];
      mem_ver = mem_ver + 1;
    end
  end

  function automatic logic [7:0] ref_byte(int k);
    if (ref_mem.exists(k)) return ref_mem[k];
    return 8'h00;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_cycle(string req, logic we, logic [19:0] a, logic bhe, logic [15:0] wd);
    check(req, 32'(bus_cyc), 32'd1, "bus_cyc");
    check(req, 32'(bus_we), 32'(we), "bus_we");
    check(req, 32'(bus_addr), 32'(a), "bus_addr");
    check(req, 32'(bus_bhe_n), 32'(bhe), "bus_bhe_n");
    if (we) check(req, 32'(bus_wdata), 32'(wd), "bus_wdata");
    check(req, 32'(req_done), 32'd0, "done during cycle");
  endtask

  // Issue one request, holding req_valid during the access when hold_busy is set (R8).
  task automatic do_req(string req, logic wr, logic wd, logic [19:0] a, logic [15:0] w, bit hold_busy);
    logic [19:0] a1;
    bit          odd_word;
    a1 = a + 20'd1;
    odd_word = wd && a[0];
    @(negedge clk);
    check("R9", 32'(bus_cyc), 32'd0, "idle before request");
    req_valid = 1'b1; req_write = wr; req_word = wd; req_addr = a; req_wdata = w;
    @(negedge clk);
    if (hold_busy) begin
      req_write = ~wr; req_addr = a ^ 20'h00F0; req_wdata = ~w;
    end else req_valid = 1'b0;
    if (!wd)
      check_cycle(req, wr, a, ~a[0], a[0] ? {w[7:0], 8'h00} : {8'h00, w[7:0]});
    else if (!a[0])
      check_cycle(req, wr, a, 1'b0, w);
    else
      check_cycle(req, wr, a, 1'b0, {w[7:0], 8'h00});
    if (odd_word) begin
      @(negedge clk);
      check_cycle(req, wr, a1, 1'b1, {8'h00, w[15:8]});
    end
    req_valid = 1'b0;
    @(negedge clk);
    check("R7", 32'(req_done), 32'd1, "done pulse");
    check("R7", 32'(bus_cyc), 32'd0, "bus idle at done");
    if (wr) begin
      ref_mem[int'(a)] = w[7:0];
      if (wd) ref_mem[int'(a1)] = w[15:8];
    end else begin
      exp_rdata = wd ? {ref_byte(int'(a1)), ref_byte(int'(a))} : {8'h00, ref_byte(int'(a))};
    end
    check(req, 32'(req_rdata), 32'(exp_rdata), wr ? "rdata kept over write (R12)" : "read data");
    @(negedge clk);
    check("R7", 32'(req_done), 32'd0, "done single cycle");
    if (hold_busy) check("R8", 32'(bus_cyc), 32'd0, "ignored request started no cycle");
  endtask

  initial begin
    #(200000 * 4);
    if (!ended) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_word = 1'b0;
    req_addr = '0; req_wdata = '0; exp_rdata = '0;
    repeat (3) @(negedge clk);
    check("R11", 32'(req_done), 32'd0, "done in reset");
    check("R11", 32'(req_rdata), 32'd0, "rdata in reset");
    check("R11", 32'(bus_cyc), 32'd0, "bus idle in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", 32'(bus_bhe_n), 32'd1, "bhe_n after reset");
    check("R9", 32'(bus_wdata), 32'd0, "idle wdata");

    // byte writes on each lane
    do_req("R1", 1'b1, 1'b0, 20'h01230, 16'hAA5C, 1'b0);
    do_req("R2", 1'b1, 1'b0, 20'h01231, 16'h77B4, 1'b0);
    // byte reads from each lane
    do_req("R3", 1'b0, 1'b0, 20'h01231, 16'h0000, 1'b0);
    do_req("R3", 1'b0, 1'b0, 20'h01230, 16'h0000, 1'b0);
    // word read across lanes assembled from the two bytes above
    do_req("R4", 1'b0, 1'b1, 20'h01230, 16'h0000, 1'b0);
    // even word write then read
    do_req("R4", 1'b1, 1'b1, 20'h40000, 16'hBEEF, 1'b0);
    do_req("R4", 1'b0, 1'b1, 20'h40000, 16'h0000, 1'b0);
    // odd word write split, held request ignored meanwhile
    do_req("R5", 1'b1, 1'b1, 20'h50001, 16'hC3D2, 1'b1);
    do_req("R6", 1'b0, 1'b1, 20'h50001, 16'h0000, 1'b1);
    do_req("R3", 1'b0, 1'b0, 20'h50002, 16'h0000, 1'b0);
    do_req("R3", 1'b0, 1'b0, 20'h50001, 16'h0000, 1'b0);
    // write leaves read result untouched
    do_req("R12", 1'b1, 1'b0, 20'h00010, 16'h0011, 1'b0);
    // wrap at top of address space
    do_req("R10", 1'b1, 1'b1, 20'hFFFFF, 16'h9A1E, 1'b0);
    do_req("R10", 1'b0, 1'b1, 20'hFFFFF, 16'h0000, 1'b0);
    do_req("R10", 1'b0, 1'b0, 20'h00000, 16'h0000, 1'b0);
    // even byte read after an even-byte write at address 0
    do_req("R1", 1'b1, 1'b0, 20'h00000, 16'h0042, 1'b0);
    do_req("R3", 1'b0, 1'b0, 20'h00000, 16'h0000, 1'b0);
    // several patterns of odd words
    for (int i = 0; i < 8; i++) begin
      logic [19:0] a;
      a = 20'h2A001 + 20'(i * 6);
      do_req("R5", 1'b1, 1'b1, a, 16'(16'h1357 * (i + 3)), i[0]);
      do_req("R6", 1'b0, 1'b1, a, 16'h0000, 1'b0);
    end

    ended = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule